// File: doc/BRIEF.md
# Banked Byte Memory

This block is an 8K x 8 byte-addressable memory built from eight narrow storage banks, each 2K locations deep and 4 bits wide. The banks are grouped into four ranks of two. Both banks in a rank share one chip select, and together they hold a full byte: one bank holds the low nibble and the other holds the high nibble. The two top address bits are decoded into a one-hot set of rank selects, so each access reaches exactly one rank. The eleven low address bits go to every bank as the location within the bank.

Every clock cycle is an access. When the write enable is high, the byte on the write data input is stored at the addressed location on the rising edge. In every cycle, including write cycles, the selected rank also captures its current contents at that address. These appear on the read data output one cycle later. Banks that are not selected neither change nor take part in the read.

Top module: `banked_byte_mem`

## Requirements
- R1: While rst_ni is low, rdata_o is 0x00.
- R2: The rank select is one-hot, and bit i is set only when addr_i[12:11] equals i.
- R3: With we_i high at a rising edge, wdata_i is stored at addr_i, and a later read of that address returns it.
- R4: A read presented with we_i low before a rising edge delivers the stored byte on rdata_o after that edge. That value holds until the next edge.
- R5: In a write cycle, rdata_o after the edge shows the byte that was stored at that address before the write.
- R6: A write changes only the addressed byte. The same in-bank offset in the other three ranks keeps its value, and banks that are not selected hold their read register.
- R7: Both nibbles of a byte are stored and returned independently: bits 3:0 in the low bank and bits 7:4 in the high bank of the rank.
- R8: Addresses on either side of each rank boundary (0x07FF/0x0800, 0x0FFF/0x1000, 0x17FF/0x1800, plus 0x0000 and 0x1FFF) hold distinct bytes without aliasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 13 | Byte address; bits 12:11 pick the rank and bits 10:0 the in-bank location |
| we_i | input | 1 | Write enable for the current cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data for the access of the previous cycle |

## Verification
Each access has one result, and it is due one clock edge after the address is presented. The result is the stored byte for a read, or the pre-write byte for a write. A stored write shows up at the first later read of that address. The bench drives each access at the falling edge, waits for the next rising edge, and samples rdata_o 1 ns later. That sample belongs to exactly that access, so the bench compares one value per cycle with no pipeline offset. Expected bytes come from an arithmetic pattern of address and pass number, computed in the bench. This covers full sweeps of all 8192 locations, the rank boundary addresses and same-offset probes across ranks.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
  localparam int unsigned ADDR_W      = 13;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned BANK_ADDR_W = 11;
  localparam int unsigned BANK_W      = 4;
  localparam int unsigned RANK_SEL_W  = ADDR_W - BANK_ADDR_W;
  localparam int unsigned N_RANKS     = 1 << RANK_SEL_W;
  localparam int unsigned N_LANES     = DATA_W / BANK_W;
endpackage

// File: rtl/bmem_bank.sv
module bmem_bank #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (cs_i && we_i) mem[addr_i] <= wdata_i;
  end

  // read-before-write: capture old contents on every selected cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (cs_i) rd_q <= mem[addr_i];
  end

  assign rdata_o = rd_q;

  // R6: unselected bank keeps its read register
  a_r6_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(rd_q));

  // R4: selected bank captures the addressed location
  a_r4_read_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |=> rd_q == $past(mem[addr_i]));
endmodule

// File: rtl/bmem_rank_dec.sv
module bmem_rank_dec #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned N_OUT = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_OUT-1:0] cs_o
);
  always_comb begin
    for (int i = 0; i < N_OUT; i++) begin
      cs_o[i] = (sel_i == SEL_W'(i));
    end
  end

  a_r2_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o) == 1);

  a_r2_cs_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o[sel_i]);
endmodule

// File: rtl/bmem_rank.sv
module bmem_rank #(
  parameter int unsigned AW    = 11,
  parameter int unsigned LANES = 2,
  parameter int unsigned LW    = 4,
  localparam int unsigned DW   = LANES * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  // lane 0 holds the low nibble, lane 1 the high nibble
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bmem_bank #(.AW(AW), .DW(LW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cs_i    (cs_i),
      .we_i    (we_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i[l*LW +: LW]),
      .rdata_o (rdata_o[l*LW +: LW])
    );
  end
endmodule

// File: rtl/banked_byte_mem.sv
module banked_byte_mem
  import bmem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N_RANKS-1:0]    cs;
  logic [RANK_SEL_W-1:0] sel_q;
  logic [DATA_W-1:0]     rank_rd [N_RANKS];

  bmem_rank_dec #(.SEL_W(RANK_SEL_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (addr_i[ADDR_W-1 -: RANK_SEL_W]),
    .cs_o   (cs)
  );

  for (genvar r = 0; r < N_RANKS; r++) begin : g_rank
    bmem_rank #(.AW(BANK_ADDR_W), .LANES(N_LANES), .LW(BANK_W)) u_rank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cs_i    (cs[r]),
      .we_i    (we_i),
      .addr_i  (addr_i[BANK_ADDR_W-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (rank_rd[r])
    );
  end

  // remember which rank answered the access of this cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= addr_i[ADDR_W-1 -: RANK_SEL_W];
  end

  assign rdata_o = rank_rd[sel_q];
endmodule

// File: tb/tb_banked_byte_mem.sv
module tb_banked_byte_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  banked_byte_mem dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] pat(int a, int k);
    return 8'(((a * 7) ^ (a >> 5) ^ (k * 8'hC3)) + k);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h (addr %04h)", req, act, exp, addr);
    end
  endtask

  // one access per cycle; returns the data delivered for this access
  task automatic access(int a, bit w, logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    addr = 13'(a); we = w; wdata = d;
    @(posedge clk);
    #1 r = rdata;
  endtask

  initial begin
    logic [7:0] r;
    int bnd [8] = '{32'h0000, 32'h07FF, 32'h0800, 32'h0FFF,
                    32'h1000, 32'h17FF, 32'h1800, 32'h1FFF};
    repeat (3) @(posedge clk);
    #1 check("R1", rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R3: fill every location
    for (int a = 0; a < 8192; a++) access(a, 1'b1, pat(a, 0), r);
    // R3/R4: read all back
    for (int a = 0; a < 8192; a++) begin
      access(a, 1'b0, 8'h00, r);
      check("R4", r, pat(a, 0));
    end
    // R5: overwrite, each write returns the previous byte
    for (int a = 0; a < 8192; a++) begin
      access(a, 1'b1, pat(a, 1), r);
      check("R5", r, pat(a, 0));
    end
    for (int a = 8191; a >= 0; a--) begin
      access(a, 1'b0, 8'h00, r);
      check("R3", r, pat(a, 1));
    end

    // R8: distinct bytes at rank boundaries
    for (int i = 0; i < 8; i++) access(bnd[i], 1'b1, 8'(8'h11 * (i + 1)), r);
    for (int i = 7; i >= 0; i--) begin
      access(bnd[i], 1'b0, 8'h00, r);
      check("R8", r, 8'(8'h11 * (i + 1)));
    end

    // R6: write offset 0x123 in rank 2 only; other ranks keep pass-1 data
    access(32'h1123, 1'b1, 8'hE7, r);
    for (int k = 0; k < 4; k++) begin
      access(k * 2048 + 32'h123, 1'b0, 8'h00, r);
      check("R6", r, (k == 2) ? 8'hE7 : pat(k * 2048 + 32'h123, 1));
    end
    // R6: neighbour in same rank untouched
    access(32'h1124, 1'b0, 8'h00, r);
    check("R6", r, pat(32'h1124, 1));

    // R7: nibbles independent
    access(32'h0456, 1'b1, 8'hF0, r);
    access(32'h0456, 1'b1, 8'h0F, r);
    check("R7", r, 8'hF0);
    access(32'h0456, 1'b1, 8'h3C, r);
    check("R7", r, 8'h0F);
    access(32'h0456, 1'b0, 8'h00, r);
    check("R7", r, 8'h3C);

    // R4: output holds between edges
    @(negedge clk); we = 1'b0; addr = 13'h0456;
    @(posedge clk); #1 r = rdata;
    #2 check("R4", rdata, r);

    // R2: rank select seen through reads from each rank's first byte
    for (int k = 0; k < 4; k++) begin
      access(k * 2048, 1'b1, 8'(8'hA0 + k), r);
    end
    for (int k = 0; k < 4; k++) begin
      access(k * 2048, 1'b0, 8'h00, r);
      check("R2", r, 8'(8'hA0 + k));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule